// File: doc/BRIEF.md
# Shadow-Latched Multi-Channel PWM Generator

This block produces up to six pulse-width-modulated outputs from one shared period counter. A programmable prescaler slows the counter. Match channel 0 sets the period, and the other six match channels place the edges of the outputs. Each output is enabled on its own. Each output also runs in one of two modes: single-edge, where it rises at the start of the period and falls on its own match, or double-edge, where it uses its own channel and the channel below it. Three double-edge outputs can run next to three single-edge outputs.

When PWM mode is on, match writes go to a shadow copy. A shadow value moves into the active compare register only when its latch bit is set and the counter then wraps. This way a duty-cycle or period change never cuts a pulse short in the middle of a period. When PWM mode is off, match writes take effect at once.

Top module: `pwm_shadow_gen`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released, `pwm_out` is all zeros. Every register resets to zero.
- R2: The register at address 9 holds the prescale value P. The register at address 8 holds the control bits: bit0 run, bit1 counter clear, bit2 PWM mode. With run=1 and clear=0, the period counter advances once every P+1 clocks. With clear=1, the prescaler and the period counter are held at zero.
- R3: When the counter advances while it equals active match 0, it returns to zero. A period is therefore (match0+1) counter steps.
- R4: Address 11 configures the outputs. Bit k-1 enables output k, and bit k+5 selects double-edge mode for output k (k=1..6). A single-edge output k is high exactly while the counter is below active match k.
- R5: A double-edge output k is high exactly while the counter is at or above active match k-1 and below active match k. It is low when match k-1 is not below match k.
- R6: An output whose enable bit is 0 is held low, whatever the counter and match values are.
- R7: Addresses 0..6 are match channels 0..6. With PWM mode on, a match write changes only the shadow copy. The output waveform does not change until that channel's latch bit is set and a period wrap follows.
- R8: Address 10 holds latch bits 0..6, one per channel. At a period wrap, every channel whose latch bit is set copies its shadow value into its active register, and all latch bits clear. Channels whose bit is clear keep their active value.
- R9: With PWM mode off, a match write updates both the shadow and the active register in the same clock edge.
- R10: `pwm_out` is registered. It reflects the counter and active match values one clock after they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 6 | PWM outputs 1..6 (bit k-1 is output k) |

## Verification
The outputs are compared on every clock against a behavioural model while the bench walks through a set of patterns:
- A mixed single- and double-edge setup at prescale 1 and prescale 0 separates the two edge rules and the step rate.
- Changing match 0 while the counter is cleared shows the period length.
- PWM-mode writes, first without and then with latch bits (including a latch on only part of the channels), distinguish shadowing, transfer at the wrap and the automatic clearing of the latch bits.
- Disabled outputs and a held counter clear show that both hold their outputs steady.

// File: rtl/pwm_shadow_gen.sv
module pwm_shadow_gen #(
  parameter int CNT_W   = 16,
  parameter int PRE_W   = 8,
  parameter int NUM_OUT = 6,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [CNT_W-1:0]   wr_data,
  output logic [NUM_OUT-1:0] pwm_out
);
  localparam int NCH = NUM_OUT + 1;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_PRE   = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] A_LATCH = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] A_OCFG  = ADDR_W'(11);

  logic [NCH-1:0][CNT_W-1:0] shd, act;
  logic [NCH-1:0]            le;
  logic                      run, clr, pmode;
  logic [PRE_W-1:0]          pre, pc;
  logic [CNT_W-1:0]          tc;
  logic [NUM_OUT-1:0]        oen, odbl, lvl;

  wire tick = run && !clr && (pc == pre);
  wire wrap = tick && (tc == act[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd <= '0; act <= '0; le <= '0;
      run <= 1'b0; clr <= 1'b0; pmode <= 1'b0;
      pre <= '0; pc <= '0; tc <= '0;
      oen <= '0; odbl <= '0;
    end else begin
      if (clr) begin
        pc <= '0;
        tc <= '0;
      end else if (run) begin
        pc <= (pc == pre) ? '0 : pc + 1'b1;
        if (tick) tc <= wrap ? '0 : tc + 1'b1;
      end
      if (wrap) begin
        for (int i = 0; i < NCH; i++)
          if (le[i]) act[i] <= shd[i];
        le <= '0;
      end
      if (wr_en) begin
        for (int i = 0; i < NCH; i++)
          if (wr_addr == ADDR_W'(i)) begin
            shd[i] <= wr_data;
            if (!pmode) act[i] <= wr_data;
          end
        if (wr_addr == A_CTRL)  {pmode, clr, run} <= wr_data[2:0];
        if (wr_addr == A_PRE)   pre <= wr_data[PRE_W-1:0];
        if (wr_addr == A_LATCH) le <= wr_data[NCH-1:0];
        if (wr_addr == A_OCFG)  {odbl, oen} <= wr_data[2*NUM_OUT-1:0];
      end
    end
  end

  for (genvar k = 1; k <= NUM_OUT; k++) begin : g_lvl
    assign lvl[k-1] = odbl[k-1] ? (tc >= act[k-1] && tc < act[k]) : (tc < act[k]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pwm_out <= '0;
    else        pwm_out <= oen & lvl;

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !clr) |=> (tc == '0)) else $error("wrap"); // R3
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(tc)) else $error("tick"); // R2
  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pwm_out & ~$past(oen)) == '0)) else $error("oen"); // R6
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pmode && !wrap) |=> $stable(act)) else $error("shadow"); // R7
  AST_LATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !(wr_en && wr_addr == A_LATCH)) |=> (le == '0)) else $error("latch"); // R8
  AST_CLR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (tc == '0 && pc == '0)) else $error("clr"); // R2
endmodule

// File: tb/pwm_shadow_gen_tb.sv
`timescale 1ns/1ps
module pwm_shadow_gen_tb;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [5:0] pwm_out;
  always #2 clk = ~clk;

  pwm_shadow_gen u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                        .wr_data(wr_data), .pwm_out(pwm_out));

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit done = 0;

  int m_act[7], m_shd[7];
  bit m_le[7];
  bit m_run, m_clr, m_pm;
  int m_pre, m_pc, m_tc;
  bit m_oen[6], m_dbl[6];
  logic [5:0] m_exp = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_act[i]) begin m_act[i] = 0; m_shd[i] = 0; m_le[i] = 0; end
      foreach (m_oen[i]) begin m_oen[i] = 0; m_dbl[i] = 0; end
      m_run = 0; m_clr = 0; m_pm = 0; m_pre = 0; m_pc = 0; m_tc = 0; m_exp = '0;
    end else begin
      bit tk, wp;
      for (int k = 1; k <= 6; k++) begin
        bit hi;
        if (m_dbl[k-1]) hi = (m_tc >= m_act[k-1]) && (m_tc < m_act[k]);
        else            hi = m_tc < m_act[k];
        m_exp[k-1] = m_oen[k-1] && hi;
      end
      tk = m_run && !m_clr && (m_pc == m_pre);
      wp = tk && (m_tc == m_act[0]);
      if (m_clr) begin m_pc = 0; m_tc = 0; end
      else if (m_run) begin
        m_pc = (m_pc == m_pre) ? 0 : m_pc + 1;
        if (tk) m_tc = wp ? 0 : (m_tc + 1) % 65536;
      end
      if (wp) for (int i = 0; i < 7; i++) begin
        if (m_le[i]) m_act[i] = m_shd[i];
        m_le[i] = 0;
      end
      if (wr_en) begin
        if (wr_addr < 7) begin
          m_shd[wr_addr] = wr_data;
          if (!m_pm) m_act[wr_addr] = wr_data;
        end
        if (wr_addr == 8) begin m_run = wr_data[0]; m_clr = wr_data[1]; m_pm = wr_data[2]; end
        if (wr_addr == 9) m_pre = wr_data[7:0];
        if (wr_addr == 10) for (int i = 0; i < 7; i++) m_le[i] = wr_data[i];
        if (wr_addr == 11) for (int i = 0; i < 6; i++) begin
          m_oen[i] = wr_data[i]; m_dbl[i] = wr_data[i+6];
        end
      end
    end
  end

  always @(negedge clk) if (!done) begin
    n_cmp++;
    if (pwm_out !== m_exp) begin
      n_bad++;
      $display("FAIL %s t=%0t pwm_out=%b expected=%b", cur_req, $time, pwm_out, m_exp);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1; wr_addr = a[3:0]; wr_data = d[15:0];
    @(negedge clk); wr_en = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cur_req = "R1";
    idle(3);
    n_cmp++;
    if (pwm_out !== 6'b0) begin n_bad++; $display("FAIL R1 pwm_out=%b expected=000000", pwm_out); end
    rst_n = 1;
    idle(2);
    cur_req = "R4";
    wr(9, 1);
    wr(0, 9); wr(1, 4); wr(2, 2); wr(3, 7); wr(4, 3); wr(5, 8); wr(6, 12);
    wr(11, (6'b101010 << 6) | 6'b111111);
    wr(8, 1);
    idle(60);
    cur_req = "R5";
    wr(3, 1);
    idle(50);
    cur_req = "R2";
    wr(9, 0); idle(40);
    wr(9, 3); idle(90);
    wr(8, 3); idle(10);
    cur_req = "R3";
    wr(0, 5); wr(9, 0);
    wr(8, 1); idle(40);
    cur_req = "R9";
    wr(8, 2); wr(0, 11); wr(1, 6); wr(8, 1); idle(40);
    cur_req = "R7";
    wr(8, 5);
    wr(1, 9); wr(0, 15); wr(4, 1);
    idle(70);
    cur_req = "R8";
    wr(10, 7'b0000011);
    idle(70);
    wr(1, 2);
    idle(60);
    wr(2, 13); wr(5, 14);
    wr(10, 7'b0000100);
    idle(60);
    wr(10, 7'b0100010);
    idle(60);
    cur_req = "R6";
    wr(11, (6'b101010 << 6) | 6'b010101);
    idle(40);
    wr(11, 0);
    idle(30);
    cur_req = "R10";
    wr(11, 6'b111111);
    idle(40);
    cur_req = "R2";
    wr(8, 7); idle(30);
    wr(8, 5); idle(30);
    finish_run();
  end
endmodule